// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a free-running watchdog made of a binary divider chain that advances on every system clock. A two-bit mode input picks one of four taps on the chain, and so one of four expiry periods. When the selected tap expires, the block sets a sticky expiry flag. The flag drives an interrupt request when both the local and the global interrupt enables are high. Expiry also starts a fixed countdown. When the countdown ends, the block issues a one-clock reset request if resets are enabled.

Software keeps the system alive by pulsing the restart input. This clears the divider chain and abandons any countdown already in progress. Software clears the flag with its own strobe. Because the chain is free-running, a system that never restarts it sees the expiry repeat once every period.

Top module: `wdt_core`

## Requirements
- R1: After synchronous reset, the flag, the interrupt request and the reset request are all 0.
- R2: The flag rises exactly 2^(BASE_EXP + STEP_EXP*mode) clock edges after the edge that samples restart, where mode is the 2-bit `tmo_sel` value 0 to 3 (defaults 2^17, 2^20, 2^23, 2^26).
- R3: The flag stays 1 until a `flag_clr` strobe or system reset. A `flag_clr` at the same edge as an expiry leaves the flag at 1.
- R4: `irq` is 1 exactly when the flag, `irq_en` and `gie` are all 1.
- R5: With `rst_en` at 1, `rst_req` is a single-clock pulse exactly GRACE_CLKS (default 512) edges after the flag rises.
- R6: With `rst_en` at 0, expiry still sets the flag but no `rst_req` pulse occurs.
- R7: A restart clears the divider chain and cancels a pending reset countdown, so no `rst_req` follows.
- R8: Without a restart, expiry repeats every period. A flag cleared after one expiry rises again one period after the previous expiry, and the reset request follows again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmo_sel | input | 2 | Expiry period select, 0 shortest to 3 longest |
| rst_en | input | 1 | Allows the reset request after the countdown |
| irq_en | input | 1 | Local watchdog interrupt enable |
| gie | input | 1 | Global interrupt enable |
| restart | input | 1 | Strobe that clears the chain and cancels the countdown |
| flag_clr | input | 1 | Software strobe that clears the expiry flag |
| flag | output | 1 | Sticky expiry flag |
| irq | output | 1 | Interrupt request |
| rst_req | output | 1 | One-clock reset request |

## Verification
Each of the four period selects is run from a fresh restart. The measured flag and reset edges show that the correct tap was decoded and that the countdown is added on top of it. The bench compares a run with resets enabled against one with resets disabled, and checks that a restart issued inside the countdown suppresses the reset. A run with no restart shows the periodic re-expiry of the free-running chain. The enable inputs are walked through their combinations while the flag is high, which separates the local enable from the global one. A clear strobe placed on the expiry edge shows that the set takes precedence over the clear.

// File: rtl/wdt_pkg.sv
// Shared types and helpers for the watchdog.
package wdt_pkg;
    typedef logic [1:0] wdt_mode_t;
    localparam int NUM_MODES = 4;

    // Divider tap width for a mode
    function automatic int tap_bits(input int base_exp, input int step_exp, input int m);
        return base_exp + step_exp * m;
    endfunction
endpackage

// File: rtl/wdt_divider.sv
// Free-running binary divider chain.
// Assumes: restart is a synchronous strobe; the count wraps freely.
module wdt_divider #(
    parameter int W = 26
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    output logic [W-1:0] cnt
);
    // Advance the chain on every clock, clear on reset or restart
    always_ff @(posedge clk) begin
        if (!rst_n || restart) cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end

    p_chain_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0));
endmodule

// File: rtl/wdt_tap_sel.sv
// Decodes the selected divider tap and reports the expiry cycle.
// Assumes: cnt comes from wdt_divider; tmo is combinational.
module wdt_tap_sel
    import wdt_pkg::*;
#(
    parameter int BASE_EXP = 17,
    parameter int STEP_EXP = 3,
    parameter int W        = BASE_EXP + STEP_EXP * (NUM_MODES - 1)
) (
    input  logic [W-1:0] cnt,
    input  wdt_mode_t    mode,
    output logic         tmo
);
    logic [NUM_MODES-1:0] hit;

    for (genvar m = 0; m < NUM_MODES; m++) begin : g_tap
        localparam int TB = tap_bits(BASE_EXP, STEP_EXP, m);
        // Terminal count of this tap: all low TB bits set
        assign hit[m] = &cnt[TB-1:0];
    end

    // Pick the tap for the current mode
    always_comb tmo = hit[mode];
endmodule

// File: rtl/wdt_grace.sv
// Countdown between expiry and reset request.
// Assumes: the period is longer than GRACE_CLKS; restart has priority.
module wdt_grace #(
    parameter int GRACE_CLKS = 512,
    localparam int GW = (GRACE_CLKS > 1) ? $clog2(GRACE_CLKS) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic restart,
    input  logic rst_en,
    output logic rst_req
);
    logic          active;
    logic [GW-1:0] remain;

    // Load on expiry, count down, fire the reset pulse at zero
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            active  <= 1'b0;
            remain  <= '0;
            rst_req <= 1'b0;
        end else begin
            rst_req <= 1'b0;
            if (expire) begin
                active <= 1'b1;
                remain <= GW'(GRACE_CLKS - 1);
            end else if (active) begin
                if (remain == '0) begin
                    active  <= 1'b0;
                    rst_req <= rst_en;
                end else begin
                    remain <= remain - 1'b1;
                end
            end
        end
    end

    p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
    p_pulse_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(rst_en));
    p_cancel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!active && !rst_req));
endmodule

// File: rtl/wdt_core.sv
// Watchdog top: divider chain, tap select, sticky flag, interrupt gate,
// reset countdown. Assumes synchronous active-low reset and strobe inputs.
module wdt_core
    import wdt_pkg::*;
#(
    parameter int BASE_EXP   = 17,
    parameter int STEP_EXP   = 3,
    parameter int GRACE_CLKS = 512,
    localparam int CW = BASE_EXP + STEP_EXP * (NUM_MODES - 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] tmo_sel,
    input  logic       rst_en,
    input  logic       irq_en,
    input  logic       gie,
    input  logic       restart,
    input  logic       flag_clr,
    output logic       flag,
    output logic       irq,
    output logic       rst_req
);
    logic [CW-1:0] cnt;
    logic          tap_hit;
    logic          expire;

    wdt_divider #(.W(CW)) u_div (
        .clk(clk), .rst_n(rst_n), .restart(restart), .cnt(cnt)
    );

    wdt_tap_sel #(.BASE_EXP(BASE_EXP), .STEP_EXP(STEP_EXP), .W(CW)) u_tap (
        .cnt(cnt), .mode(wdt_mode_t'(tmo_sel)), .tmo(tap_hit)
    );

    // A restart in the expiry cycle suppresses that expiry
    always_comb expire = tap_hit && !restart;

    wdt_grace #(.GRACE_CLKS(GRACE_CLKS)) u_grace (
        .clk(clk), .rst_n(rst_n), .expire(expire), .restart(restart),
        .rst_en(rst_en), .rst_req(rst_req)
    );

    // Sticky flag: set wins over a software clear
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (expire)   flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end

    // Interrupt gate
    always_comb irq = flag && irq_en && gie;

    p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag);
    p_irq_needs_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);
    p_reset_after_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> flag || $past(flag_clr));
endmodule

// File: tb/tb_wdt_core.sv
// Scoreboard bench: driver tasks queue expected events (kind, edge number),
// a negedge monitor pops and compares observed flag rises and reset pulses.
module tb_wdt_core;
    localparam int CLK_PERIOD = 10;
    localparam int BASE = 10;
    localparam int STEP = 1;
    localparam int GRACE = 512;
    localparam int WATCHDOG = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] tmo_sel = 2'd0;
    logic rst_en = 1'b0, irq_en = 1'b0, gie = 1'b0;
    logic restart = 1'b0, flag_clr = 1'b0;
    logic flag, irq, rst_req;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    logic prev_flag = 1'b0;
    logic mon_on = 1'b0;

    typedef struct { int kind; int at; string req; } exp_t; // kind 1 flag rise, 2 reset pulse
    exp_t q[$];

    wdt_core #(.BASE_EXP(BASE), .STEP_EXP(STEP), .GRACE_CLKS(GRACE)) dut (
        .clk(clk), .rst_n(rst_n), .tmo_sel(tmo_sel), .rst_en(rst_en),
        .irq_en(irq_en), .gie(gie), .restart(restart), .flag_clr(flag_clr),
        .flag(flag), .irq(irq), .rst_req(rst_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int period(input int m);
        return 1 << (BASE + STEP * m);
    endfunction

    task automatic check(input string req, input logic act, input logic expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b at edge %0d", req, act, expv, cyc);
        end
    endtask

    task automatic push(input int kind, input int at, input string req);
        exp_t e;
        e.kind = kind; e.at = at; e.req = req;
        q.push_back(e);
    endtask

    // Monitor: each observed event must match the queue front
    task automatic observe(input int kind);
        checks++;
        if (q.size() == 0) begin
            fails++;
            $display("FAIL unexpected: actual kind %0d at edge %0d expected none", kind, cyc);
        end else begin
            exp_t e = q.pop_front();
            if (e.kind != kind || e.at != cyc) begin
                fails++;
                $display("FAIL %s: actual kind %0d at edge %0d expected kind %0d at edge %0d",
                         e.req, kind, cyc, e.kind, e.at);
            end
        end
    endtask

    always @(negedge clk) begin
        if (mon_on) begin
            if (flag && !prev_flag) observe(1);
            if (rst_req) observe(2);
        end
        prev_flag = flag;
    end

    task automatic wait_edge(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    // Restart (with flag clear) sampled at the next edge; returns that edge
    task automatic do_restart(output int n);
        restart = 1'b1; flag_clr = 1'b1; n = cyc + 1;
        @(negedge clk);
        restart = 1'b0; flag_clr = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 flag", flag, 1'b0);
        check("R1 irq", irq, 1'b0);
        check("R1 rst_req", rst_req, 1'b0);
        rst_n = 1'b1;
        mon_on = 1'b1;

        // Mode 0, resets on: R2, R5, R4
        tmo_sel = 2'd0; rst_en = 1'b1; irq_en = 1'b1; gie = 1'b1;
        do_restart(n);
        push(1, n + period(0), "R2 mode0");
        push(2, n + period(0) + GRACE, "R5 mode0");
        wait_edge(n + period(0) + 2);
        check("R4 irq all enables", irq, 1'b1);
        wait_edge(n + period(0) + GRACE + 20);

        // Mode 1, resets off: R2, R6, R4 enable walk
        tmo_sel = 2'd1; rst_en = 1'b0; gie = 1'b0;
        do_restart(n);
        push(1, n + period(1), "R2 mode1 / R6 flag");
        wait_edge(n + period(1) + 2);
        check("R4 irq gie off", irq, 1'b0);
        gie = 1'b1; #1;
        check("R4 irq gie on", irq, 1'b1);
        irq_en = 1'b0; #1;
        check("R4 irq local off", irq, 1'b0);
        irq_en = 1'b1;
        wait_edge(n + period(1) + GRACE + 20);
        check("R6 flag kept", flag, 1'b1);

        // Mode 2, resets on, restart inside countdown: R2, R7, R3
        tmo_sel = 2'd2; rst_en = 1'b1;
        do_restart(n);
        push(1, n + period(2), "R2 mode2");
        wait_edge(n + period(2) + 100);
        restart = 1'b1; @(negedge clk); restart = 1'b0;
        wait_edge(n + period(2) + GRACE + 100);
        check("R7 no reset after restart", rst_req, 1'b0);
        check("R3 flag sticky", flag, 1'b1);
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
        check("R3 flag cleared", flag, 1'b0);

        // Mode 3, no restart: R2, R5, R8 re-expiry
        tmo_sel = 2'd3;
        do_restart(n);
        push(1, n + period(3), "R2 mode3");
        push(2, n + period(3) + GRACE, "R5 mode3");
        wait_edge(n + period(3) + GRACE + 50);
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
        check("R3 clear before re-expiry", flag, 1'b0);
        push(1, n + 2 * period(3), "R8 re-expiry flag");
        push(2, n + 2 * period(3) + GRACE, "R8 re-expiry reset");
        wait_edge(n + 2 * period(3) + GRACE + 20);

        // Mode 0, clear on the expiry edge: R3 set wins
        tmo_sel = 2'd0; rst_en = 1'b0;
        do_restart(n);
        push(1, n + period(0), "R3 set beats clear");
        wait_edge(n + period(0) - 1);
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
        check("R3 flag after clash", flag, 1'b1);
        do_restart(n);
        wait_edge(n + 20);

        checks++;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL %s: actual missing event expected at edge %0d", q[0].req, q[0].at);
        end
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule